// File: doc/BRIEF.md
# Grouped-Priority Interrupt Arbiter

This block picks one winner among a bank of interrupt request lines and two fixed top-rank exceptions (a reset exception and a hard-fault exception), and tells the core whether that winner should interrupt the handler now running. Each request line has a 3-bit programmable priority, where a smaller value means more urgent. A split setting divides every priority into an upper group field and a lower subpriority field. The full value orders the pending requests. Only the group field decides whether the running handler is preempted.

Requests are captured on their rising edge into pending flags. A flag stays set until the core acknowledges that exception number, so a request that loses arbitration, or that cannot preempt, is not lost. The active handler is named by its exception number. The block looks up that handler's group itself from the same priority table and split setting. When no handler is active, any pending request raises a preempt request.

Arbitration over all pending sources is combinational and the three result outputs are registered. Priorities are loaded through a single-entry write port.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After a synchronous reset, all pending flags are clear, every line priority is 0, and `sel_valid` and `preempt_req` are low.
- R2: A pending flag is set when its request input rises. It stays set, whether the request holds or drops, until an acknowledge names its exception number. A request held high after that acknowledge does not set the flag again.
- R3: Exception numbers are 0 for the reset exception, 1 for hard fault, and 2+i for request line i. A pending reset exception outranks hard fault, and hard fault outranks every line, whatever the line priorities are.
- R4: Among pending lines, the one with the numerically lowest priority value is selected.
- R5: Among pending lines with equal priority values, the lowest exception number is selected.
- R6: `split_sel` (0 to 3) gives the number of low priority bits that form the subpriority. The group is the priority shifted right by `split_sel`. A winner in the same group as the active handler does not preempt, even with a better subpriority. A change of `split_sel` shows at the outputs after the next clock edge.
- R7: With a handler active, `preempt_req` is high only when the winner's rank is strictly better than the active handler's rank. Rank is compared on class first (reset, then hard fault, then line) and then on group. An equal rank never preempts.
- R8: When `act_valid` is low, any pending source makes `preempt_req` high together with `sel_valid`.
- R9: The outputs are registered. A request sampled high at a clock edge sets its flag at that edge and reaches the outputs at the following edge. Acknowledges, split, active-handler and priority changes reach the outputs one edge after they take effect.
- R10: A priority write on `prio_we` updates line `prio_widx` at the clock edge. Arbitration uses the new value from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_req | input | NUM_LINES | Request line levels; rising edge sets pending |
| rst_exc_req | input | 1 | Reset exception request (number 0) |
| fault_req | input | 1 | Hard-fault request (number 1) |
| prio_we | input | 1 | Priority write strobe |
| prio_widx | input | LINE_W | Line index to write |
| prio_wdata | input | PRIO_W | Priority value to write |
| split_sel | input | 2 | Number of subpriority bits |
| act_valid | input | 1 | A handler is running |
| act_num | input | NUM_W | Exception number of the running handler |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_num | input | NUM_W | Exception number whose pending flag is cleared |
| sel_valid | output | 1 | Some source is pending |
| sel_num | output | NUM_W | Exception number of the winner |
| preempt_req | output | 1 | Winner should preempt the running handler |

## Verification
The bench targets the split between ordering and preemption. A design that compares whole priorities for preemption would raise `preempt_req` for a same-group, better-subpriority request. A design that ignores the split would miss the preemption that appears once `split_sel` drops to 0. Equal-priority ties and equal-rank active handlers are both driven. A wrong tie-break shows as a higher exception number selected, and a non-strict comparison shows as a spurious preempt. The bench also holds a request level across its acknowledge, so a design that sets pending on the level instead of the edge re-selects it. It checks the one-cycle gap between a flag being set and the output, so an extra or missing register is caught.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  // Fixed sources occupy the lowest exception numbers.
  localparam int FIXED_SRCS = 2;
  localparam int NUM_RESET  = 0;
  localparam int NUM_FAULT  = 1;

  // Rank class: smaller value is more urgent.
  typedef enum logic [1:0] {
    CL_RESET = 2'd0,
    CL_FAULT = 2'd1,
    CL_LINE  = 2'd2,
    CL_IDLE  = 2'd3
  } exc_class_e;

endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs #(
  parameter int NUM_LINES = 8,
  parameter int PRIO_W    = 3,
  parameter int LINE_W    = 3
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               we,
  input  logic [LINE_W-1:0]                  widx,
  input  logic [PRIO_W-1:0]                  wdata,
  output logic [NUM_LINES-1:0][PRIO_W-1:0]   prio_o
);

  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q <= '0;
    end else if (we && (32'(widx) < NUM_LINES)) begin
      prio_q[widx] <= wdata;
    end
  end

  assign prio_o = prio_q;

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_SRC = 10,
  parameter int NUM_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req,
  input  logic               ack_valid,
  input  logic [NUM_W-1:0]   ack_num,
  output logic [NUM_SRC-1:0] pend_o
);

  logic [NUM_SRC-1:0] req_q;
  logic [NUM_SRC-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= req;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    logic rise;
    logic clr;
    assign rise = req[i] && !req_q[i];
    assign clr  = ack_valid && (ack_num == NUM_W'(i));
    always_ff @(posedge clk) begin
      if (rst)       pend_q[i] <= 1'b0;
      else if (rise) pend_q[i] <= 1'b1;
      else if (clr)  pend_q[i] <= 1'b0;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NUM_SRC = 10,
  parameter int NUM_W   = 4,
  parameter int KEY_W   = 5
) (
  input  logic [NUM_SRC-1:0]            pend,
  input  logic [NUM_SRC-1:0][KEY_W-1:0] keys,
  output logic                          found,
  output logic [NUM_W-1:0]              win_idx,
  output logic [KEY_W-1:0]              win_key
);

  // Ascending scan with strict compare: equal keys keep the lower number.
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_key = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i] && (!found || (keys[i] < win_key))) begin
        found   = 1'b1;
        win_idx = NUM_W'(i);
        win_key = keys[i];
      end
    end
  end

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
  parameter int NUM_LINES = 8,
  parameter int PRIO_W    = 3,
  parameter int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  parameter int NUM_W     = $clog2(NUM_LINES + irq_arb_pkg::FIXED_SRCS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] line_req,
  input  logic                 rst_exc_req,
  input  logic                 fault_req,
  input  logic                 prio_we,
  input  logic [LINE_W-1:0]    prio_widx,
  input  logic [PRIO_W-1:0]    prio_wdata,
  input  logic [1:0]           split_sel,
  input  logic                 act_valid,
  input  logic [NUM_W-1:0]     act_num,
  input  logic                 ack_valid,
  input  logic [NUM_W-1:0]     ack_num,
  output logic                 sel_valid,
  output logic [NUM_W-1:0]     sel_num,
  output logic                 preempt_req
);
  import irq_arb_pkg::*;

  localparam int NUM_SRC = NUM_LINES + FIXED_SRCS;
  localparam int CLS_W   = $bits(exc_class_e);
  localparam int KEY_W   = CLS_W + PRIO_W;

  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_SRC-1:0]               req_all;
  logic [NUM_SRC-1:0]               pend_q;
  logic [NUM_SRC-1:0][KEY_W-1:0]    keys;
  logic                             found;
  logic [NUM_W-1:0]                 win_idx;
  logic [KEY_W-1:0]                 win_key;

  irq_prio_regs #(
    .NUM_LINES (NUM_LINES),
    .PRIO_W    (PRIO_W),
    .LINE_W    (LINE_W)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (prio_we),
    .widx   (prio_widx),
    .wdata  (prio_wdata),
    .prio_o (prio_q)
  );

  assign req_all = {line_req, fault_req, rst_exc_req};

  irq_pend_bank #(
    .NUM_SRC (NUM_SRC),
    .NUM_W   (NUM_W)
  ) u_pend (
    .clk       (clk),
    .rst       (rst),
    .req       (req_all),
    .ack_valid (ack_valid),
    .ack_num   (ack_num),
    .pend_o    (pend_q)
  );

  // Ordering key per source: class above full priority value.
  assign keys[NUM_RESET] = {CL_RESET, {PRIO_W{1'b0}}};
  assign keys[NUM_FAULT] = {CL_FAULT, {PRIO_W{1'b0}}};
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_key
    assign keys[FIXED_SRCS + i] = {CL_LINE, prio_q[i]};
  end

  irq_pick #(
    .NUM_SRC (NUM_SRC),
    .NUM_W   (NUM_W),
    .KEY_W   (KEY_W)
  ) u_pick (
    .pend    (pend_q),
    .keys    (keys),
    .found   (found),
    .win_idx (win_idx),
    .win_key (win_key)
  );

  // Preemption rank: class above group field only.
  logic [CLS_W-1:0]  win_cls;
  logic [PRIO_W-1:0] win_grp;
  logic [CLS_W-1:0]  act_cls;
  logic [PRIO_W-1:0] act_grp;
  logic [NUM_W-1:0]  act_off;
  logic              preempt_nxt;

  assign win_cls = win_key[KEY_W-1 -: CLS_W];
  assign win_grp = win_key[PRIO_W-1:0] >> split_sel;
  assign act_off = act_num - NUM_W'(FIXED_SRCS);

  always_comb begin
    act_cls = CL_IDLE;
    act_grp = '1;
    if (act_valid) begin
      if (act_num == NUM_W'(NUM_RESET)) begin
        act_cls = CL_RESET;
        act_grp = '0;
      end else if (act_num == NUM_W'(NUM_FAULT)) begin
        act_cls = CL_FAULT;
        act_grp = '0;
      end else if (32'(act_off) < NUM_LINES) begin
        act_cls = CL_LINE;
        act_grp = prio_q[act_off[LINE_W-1:0]] >> split_sel;
      end
    end
  end

  assign preempt_nxt = found && ({win_cls, win_grp} < {act_cls, act_grp});

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_valid   <= 1'b0;
      sel_num     <= '0;
      preempt_req <= 1'b0;
    end else begin
      sel_valid   <= found;
      sel_num     <= win_idx;
      preempt_req <= preempt_nxt;
    end
  end

endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
  parameter int NUM_SRC = 10,
  parameter int NUM_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               act_valid,
  input logic [NUM_W-1:0]   act_num,
  input logic               ack_valid,
  input logic [NUM_W-1:0]   ack_num,
  input logic [NUM_SRC-1:0] pend,
  input logic               sel_valid,
  input logic [NUM_W-1:0]   sel_num,
  input logic               preempt_req
);

  // R1: reset forces the outputs low
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!sel_valid && !preempt_req));

  // R2: a flag only clears through its own acknowledge
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_hold
    a_r2_pend_holds: assert property (@(posedge clk) disable iff (rst)
      (pend[i] && !(ack_valid && ack_num == NUM_W'(i))) |=> pend[i]);
  end

  // R3: pending reset exception always wins
  a_r3_reset_wins: assert property (@(posedge clk) disable iff (rst)
    pend[0] |=> (sel_valid && sel_num == '0));

  // R7: nothing preempts an active reset handler
  a_r7_reset_unpreempted: assert property (@(posedge clk) disable iff (rst)
    (act_valid && act_num == '0) |=> !preempt_req);

  // R7: a preempt request always carries a winner
  a_r7_preempt_has_winner: assert property (@(posedge clk) disable iff (rst)
    preempt_req |-> sel_valid);

  // R8: idle core plus pending source gives a preempt request
  a_r8_idle_preempts: assert property (@(posedge clk) disable iff (rst)
    (!act_valid && (|pend)) |=> preempt_req);

  // R9: no pending source, no valid winner one edge later
  a_r9_empty_invalid: assert property (@(posedge clk) disable iff (rst)
    !(|pend) |=> !sel_valid);

endmodule

bind irq_prio_arbiter irq_arb_chk #(
  .NUM_SRC (NUM_SRC),
  .NUM_W   (NUM_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .act_valid   (act_valid),
  .act_num     (act_num),
  .ack_valid   (ack_valid),
  .ack_num     (ack_num),
  .pend        (pend_q),
  .sel_valid   (sel_valid),
  .sel_num     (sel_num),
  .preempt_req (preempt_req)
);

// File: tb/irq_prio_arbiter_tb.sv
`timescale 1ns/1ps
module irq_prio_arbiter_tb;

  localparam int NL = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] line_req = '0;
  logic          rst_exc_req = 1'b0;
  logic          fault_req = 1'b0;
  logic          prio_we = 1'b0;
  logic [2:0]    prio_widx = '0;
  logic [2:0]    prio_wdata = '0;
  logic [1:0]    split_sel = '0;
  logic          act_valid = 1'b0;
  logic [3:0]    act_num = '0;
  logic          ack_valid = 1'b0;
  logic [3:0]    ack_num = '0;
  logic          sel_valid;
  logic [3:0]    sel_num;
  logic          preempt_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_prio_arbiter #(.NUM_LINES(NL)) u_dut (
    .clk(clk), .rst(rst), .line_req(line_req), .rst_exc_req(rst_exc_req),
    .fault_req(fault_req), .prio_we(prio_we), .prio_widx(prio_widx),
    .prio_wdata(prio_wdata), .split_sel(split_sel), .act_valid(act_valid),
    .act_num(act_num), .ack_valid(ack_valid), .ack_num(ack_num),
    .sel_valid(sel_valid), .sel_num(sel_num), .preempt_req(preempt_req)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic v, input logic [3:0] n,
                            input logic p);
    checks++;
    if (sel_valid !== v || (v && sel_num !== n) || preempt_req !== p) begin
      errors++;
      $display("FAIL %s: got valid=%0b num=%0d preempt=%0b, expected valid=%0b num=%0d preempt=%0b",
               tag, sel_valid, sel_num, preempt_req, v, n, p);
    end
  endtask

  // One-cycle request pulse; outputs are valid on return.
  task automatic pulse(input logic [NL-1:0] lines, input logic rs, input logic hf);
    line_req = lines; rst_exc_req = rs; fault_req = hf;
    tick(1);
    line_req = '0; rst_exc_req = 1'b0; fault_req = 1'b0;
    tick(1);
  endtask

  task automatic ack(input logic [3:0] n);
    ack_valid = 1'b1; ack_num = n;
    tick(1);
    ack_valid = 1'b0;
    tick(1);
  endtask

  task automatic wprio(input logic [2:0] idx, input logic [2:0] val);
    prio_we = 1'b1; prio_widx = idx; prio_wdata = val;
    tick(1);
    prio_we = 1'b0;
  endtask

  task automatic clear_all();
    for (int n = 0; n < NL + 2; n++) ack(4'(n));
  endtask

  task automatic t_reset_state();
    expect_out("R1 outputs after reset", 1'b0, 4'd0, 1'b0);
    pulse(8'b0000_0011, 1'b0, 1'b0);
    expect_out("R1/R5 default prio 0, lowest number", 1'b1, 4'd2, 1'b1);
    clear_all();
    expect_out("R2 all acked", 1'b0, 4'd0, 1'b0);
  endtask

  task automatic t_order();
    wprio(3'd3, 3'd1); wprio(3'd5, 3'd4); wprio(3'd0, 3'd5);
    pulse(8'b0010_1001, 1'b0, 1'b0);
    expect_out("R4 lowest value wins", 1'b1, 4'd5, 1'b1);
    ack(4'd5);
    expect_out("R4 next best", 1'b1, 4'd7, 1'b1);
    ack(4'd7);
    expect_out("R2 loser kept pending", 1'b1, 4'd2, 1'b1);
    line_req = 8'b0000_1000;
    tick(2);
    expect_out("R2 edge sets pending", 1'b1, 4'd5, 1'b1);
    ack(4'd5);
    expect_out("R2 held level not re-pended", 1'b1, 4'd2, 1'b1);
    line_req = '0;
    ack(4'd2);
    expect_out("R2 empty after acks", 1'b0, 4'd0, 1'b0);
  endtask

  task automatic t_timing();
    line_req = 8'b0000_1000;
    tick(1);
    expect_out("R9 flag set, output not yet", 1'b0, 4'd0, 1'b0);
    line_req = '0;
    tick(1);
    expect_out("R9 output one edge later", 1'b1, 4'd5, 1'b1);
    ack(4'd5);
  endtask

  task automatic t_fixed();
    pulse(8'b0000_1000, 1'b1, 1'b1);
    expect_out("R3 reset exception first", 1'b1, 4'd0, 1'b1);
    ack(4'd0);
    expect_out("R3 hard fault over lines", 1'b1, 4'd1, 1'b1);
    ack(4'd1);
    expect_out("R3 line after fixed", 1'b1, 4'd5, 1'b1);
    ack(4'd5);
  endtask

  task automatic t_ties();
    wprio(3'd2, 3'd3); wprio(3'd6, 3'd3);
    pulse(8'b0100_0100, 1'b0, 1'b0);
    expect_out("R5 tie lowest number", 1'b1, 4'd4, 1'b1);
    ack(4'd4);
    expect_out("R5 tie other", 1'b1, 4'd8, 1'b1);
    ack(4'd8);
  endtask

  task automatic t_split();
    wprio(3'd1, 3'd2); wprio(3'd4, 3'd3);
    split_sel = 2'd1; act_valid = 1'b1; act_num = 4'd6;
    pulse(8'b0000_0010, 1'b0, 1'b0);
    expect_out("R6 same group better sub no preempt", 1'b1, 4'd3, 1'b0);
    split_sel = 2'd0;
    tick(1);
    expect_out("R6 split 0 makes group better", 1'b1, 4'd3, 1'b1);
    ack(4'd3);
    act_valid = 1'b0;
  endtask

  task automatic t_preempt();
    split_sel = 2'd0; act_valid = 1'b1; act_num = 4'd2;
    wprio(3'd7, 3'd5);
    pulse(8'b1000_0000, 1'b0, 1'b0);
    expect_out("R7 equal group no preempt", 1'b1, 4'd9, 1'b0);
    pulse(8'b0010_0000, 1'b0, 1'b0);
    expect_out("R7 strictly better preempts", 1'b1, 4'd7, 1'b1);
    ack(4'd7); ack(4'd9);
    act_num = 4'd1;
    pulse(8'b0000_1000, 1'b0, 1'b0);
    expect_out("R7 line cannot preempt hard fault", 1'b1, 4'd5, 1'b0);
    pulse(8'b0000_0000, 1'b1, 1'b0);
    expect_out("R7/R3 reset preempts hard fault", 1'b1, 4'd0, 1'b1);
    ack(4'd0); ack(4'd5);
    act_valid = 1'b0;
  endtask

  task automatic t_idle();
    act_valid = 1'b0;
    pulse(8'b0100_0000, 1'b0, 1'b0);
    expect_out("R8 idle core preempt", 1'b1, 4'd8, 1'b1);
    ack(4'd8);
  endtask

  task automatic t_write();
    pulse(8'b0100_0100, 1'b0, 1'b0);
    expect_out("R10 before write", 1'b1, 4'd4, 1'b1);
    wprio(3'd6, 3'd0);
    tick(1);
    expect_out("R10 written prio used", 1'b1, 4'd8, 1'b1);
    clear_all();
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset_state();
    t_order();
    t_timing();
    t_fixed();
    t_ties();
    t_split();
    t_preempt();
    t_idle();
    t_write();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got running, expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule